// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits in one channel of a DRAM controller and decides, each clock cycle, which single DRAM command goes out. It keeps a small buffer of pending read and write requests. Each request carries a bank, a row, a column and a read/write flag. The block also tracks, for every bank, whether a row is open and which row that is. From this it works out the next command each request needs. A request whose row is already open needs a column command (read or write). A request to an idle bank needs an activate. A request to a bank that has a different row open needs a precharge.

Priority is applied to these commands, not to whole requests. In the default mode, column commands beat row commands, and within each class the oldest request wins. A strict arrival-order mode can be selected instead, in which only the oldest request may make progress. Row-buffer management is selectable. Under the open-row policy the row stays open after a column access. Under the closed-row policy a column command carries an automatic precharge unless another buffered request still wants the same row. A request leaves the buffer in the cycle its read or write command issues.

A simple per-bank ready input stands in for all DRAM timing: a command may go to a bank only while that bank's ready bit is high. The command outputs are combinational from the registered buffer and bank state, and the command counts as issued on the clock edge that ends the cycle in which `cmd_valid` is high.

Top module: `dram_cmd_sched`

## Requirements
- R1: The command needed by a request is READ (kind 0) or WRITE (kind 1) when its bank has its row open, ACTIVATE (kind 2) when its bank has no open row, and PRECHARGE (kind 3) when its bank has a different row open. `cmd_bank` always carries the request's bank. For ACTIVATE, `cmd_row` carries its row. For READ and WRITE, `cmd_col` carries its column.
- R2: In the default mode (`fcfs_mode` = 0), an eligible column command is issued in preference to any eligible row command, whatever their ages.
- R3: Within the class chosen, the command of the request that arrived earliest is issued.
- R4: With `close_policy` = 0, `cmd_autopre` is 0 on every column command, and the row stays open afterwards.
- R5: With `close_policy` = 1, `cmd_autopre` is 1 on a column command exactly when no other buffered request targets the same bank and row. When it is 1, that bank is closed after the command.
- R6: With `fcfs_mode` = 1, only the oldest buffered request may issue a command. If its bank is not ready, no command is issued, even when younger requests are eligible.
- R7: A command is issued only to a bank whose `bank_ready` bit is 1. With no eligible command, `cmd_valid` is 0.
- R8: ACTIVATE opens the given row in its bank. PRECHARGE, or a column command with `cmd_autopre` = 1, closes the bank. A READ or WRITE removes its request from the buffer.
- R9: `enq_ready` is 0 exactly when DEPTH requests are buffered. A request accepted at a clock edge can be chosen in the cycle right after that edge.
- R10: After a synchronous active-low reset, the buffer is empty, all banks are closed, `cmd_valid` is 0 and `enq_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fcfs_mode | input | 1 | 1 selects strict arrival-order issue |
| close_policy | input | 1 | 1 selects the closed-row policy |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | Buffer has a free slot |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_col | input | COL_W | Column of the new request |
| enq_write | input | 1 | 1 for write, 0 for read |
| bank_ready | input | NBANK | Per-bank permission to take a command |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 read, 1 write, 2 activate, 3 precharge |
| cmd_bank | output | BANK_W | Target bank |
| cmd_row | output | ROW_W | Row of the chosen request |
| cmd_col | output | COL_W | Column of the chosen request |
| cmd_autopre | output | 1 | Column command closes the bank afterwards |

## Verification
A wrong bit in the age order or the buffer shows up as the wrong request winning the next time two requests compete. The bench compares every output in every cycle, so such a fault is reported in that same cycle. A wrong open-row record shows up as a wrong command kind. For example, an activate is sent to an open bank, or a read is sent where a precharge was due. That fault appears at the first command to that bank after the corruption, and the shadow-state assertions catch it at the same edge. A slot that is not freed or not filled appears as a mismatch in `enq_ready`, or as a request that never issues, within the cycles needed to reach it in the buffer.

// File: rtl/sched_pkg.sv
// Shared encodings for the DRAM command scheduler.
package sched_pkg;
    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_ACT = 2'd2,
        CMD_PRE = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/req_store.sv
// Request buffer with an arrival-order matrix.
// older[i][j] = 1 means slot j holds a request that arrived before slot i.
// Assumes at most one enqueue and one dequeue per cycle. A slot freed by a
// dequeue is not reused in the same cycle.
module req_store #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             enq_valid,
    input  logic [BANK_W-1:0]                enq_bank,
    input  logic [ROW_W-1:0]                 enq_row,
    input  logic [COL_W-1:0]                 enq_col,
    input  logic                             enq_write,
    output logic                             enq_ready,
    input  logic                             deq_valid,
    input  logic [IDX_W-1:0]                 deq_idx,
    output logic [DEPTH-1:0]                 ent_valid,
    output logic [DEPTH-1:0][BANK_W-1:0]     ent_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]      ent_row,
    output logic [DEPTH-1:0][COL_W-1:0]      ent_col,
    output logic [DEPTH-1:0]                 ent_write,
    output logic [DEPTH-1:0][DEPTH-1:0]      older
);
    logic [IDX_W-1:0] free_idx;
    logic [DEPTH-1:0] deq_mask;
    logic [DEPTH-1:0] kept;
    logic             accept;

    // Find the lowest free slot.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Work out which entries survive this cycle and whether an enqueue is taken.
    always_comb begin
        deq_mask  = deq_valid ? (DEPTH'(1) << deq_idx) : '0;
        kept      = ent_valid & ~deq_mask;
        enq_ready = ~&ent_valid;
        accept    = enq_valid && enq_ready;
    end

    // Update the slot contents and the arrival order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            older     <= '0;
        end else begin
            ent_valid <= kept;
            if (accept) begin
                ent_valid[free_idx] <= 1'b1;
                ent_bank[free_idx]  <= enq_bank;
                ent_row[free_idx]   <= enq_row;
                ent_col[free_idx]   <= enq_col;
                ent_write[free_idx] <= enq_write;
                for (int i = 0; i < DEPTH; i++) begin
                    older[i][free_idx] <= 1'b0;
                end
                older[free_idx] <= kept;
            end
        end
    end
endmodule

// File: rtl/bank_tracker.sv
// Per-bank open-row record.
// Follows the issued commands: activate opens a row, and precharge or a
// column command with auto-precharge closes the bank.
module bank_tracker #(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 14,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_kind,
    input  logic [BANK_W-1:0]             cmd_bank,
    input  logic [ROW_W-1:0]              cmd_row,
    input  logic                          cmd_autopre,
    output logic [NBANK-1:0]              open_valid,
    output logic [NBANK-1:0][ROW_W-1:0]   open_row
);
    import sched_pkg::*;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_me;
        // Decode whether this cycle's command targets this bank.
        always_comb hit_me = cmd_valid && (cmd_bank == BANK_W'(b));

        // Keep the open flag and the open row of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_valid[b] <= 1'b0;
                open_row[b]   <= '0;
            end else if (hit_me) begin
                if (cmd_kind == CMD_ACT) begin
                    open_valid[b] <= 1'b1;
                    open_row[b]   <= cmd_row;
                end else if (cmd_kind == CMD_PRE) begin
                    open_valid[b] <= 1'b0;
                end else if (cmd_autopre) begin
                    open_valid[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cmd_picker.sv
// Command selection.
// Classifies each buffered request by the command it needs, keeps only the
// requests whose bank is ready, and picks one. In the default mode column
// commands come first, then the oldest request. In arrival-order mode only
// the oldest request may issue. Also decides auto-precharge.
module cmd_picker #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 4,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    localparam int BANK_W = $clog2(NBANK),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]               ent_valid,
    input  logic [DEPTH-1:0][BANK_W-1:0]   ent_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]    ent_row,
    input  logic [DEPTH-1:0][COL_W-1:0]    ent_col,
    input  logic [DEPTH-1:0]               ent_write,
    input  logic [DEPTH-1:0][DEPTH-1:0]    older,
    input  logic [NBANK-1:0]               open_valid,
    input  logic [NBANK-1:0][ROW_W-1:0]    open_row,
    input  logic [NBANK-1:0]               bank_ready,
    input  logic                           fcfs_mode,
    input  logic                           close_policy,
    output logic                           cmd_valid,
    output logic [1:0]                     cmd_kind,
    output logic [BANK_W-1:0]              cmd_bank,
    output logic [ROW_W-1:0]               cmd_row,
    output logic [COL_W-1:0]               cmd_col,
    output logic                           cmd_autopre,
    output logic [IDX_W-1:0]               pick_idx
);
    import sched_pkg::*;

    logic [DEPTH-1:0] hit, is_open, rdy;
    logic [DEPTH-1:0] head, base, col_c, row_c, pool, win, share;

    // Return the members of s that have no older member in s.
    function automatic logic [DEPTH-1:0] oldest_of(
        input logic [DEPTH-1:0] s,
        input logic [DEPTH-1:0][DEPTH-1:0] o
    );
        logic [DEPTH-1:0] r;
        for (int i = 0; i < DEPTH; i++) begin
            r[i] = s[i] && !(|(s & o[i]));
        end
        return r;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_cls
        // Classify request i against its bank's state.
        always_comb begin
            is_open[i] = open_valid[ent_bank[i]];
            hit[i]     = is_open[i] && (open_row[ent_bank[i]] == ent_row[i]);
            rdy[i]     = ent_valid[i] && bank_ready[ent_bank[i]];
        end
    end

    // Pick the winning request.
    always_comb begin
        head  = oldest_of(ent_valid, older);
        base  = fcfs_mode ? head : ent_valid;
        col_c = base & rdy & hit;
        row_c = base & rdy & ~hit;
        pool  = (|col_c) ? col_c : row_c;
        win   = oldest_of(pool, older);
        pick_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win[i]) pick_idx = IDX_W'(i);
        end
    end

    // Form the command fields and the auto-precharge decision.
    always_comb begin
        cmd_valid = |win;
        cmd_bank  = ent_bank[pick_idx];
        cmd_row   = ent_row[pick_idx];
        cmd_col   = ent_col[pick_idx];
        if (hit[pick_idx]) begin
            cmd_kind = ent_write[pick_idx] ? CMD_WR : CMD_RD;
        end else if (is_open[pick_idx]) begin
            cmd_kind = CMD_PRE;
        end else begin
            cmd_kind = CMD_ACT;
        end
        for (int i = 0; i < DEPTH; i++) begin
            share[i] = ent_valid[i] && (IDX_W'(i) != pick_idx)
                       && (ent_bank[i] == cmd_bank) && (ent_row[i] == cmd_row);
        end
        cmd_autopre = cmd_valid && close_policy && hit[pick_idx] && !(|share);
    end
endmodule

// File: rtl/dram_cmd_sched.sv
// Top level of the per-channel DRAM command scheduler.
// Wires the request buffer, the bank record and the picker together. A read
// or write issued in a cycle removes its request at the closing clock edge.
// Assumes bank_ready already covers all DRAM timing limits.
module dram_cmd_sched #(
    parameter int DEPTH = 8,
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int BANK_W = $clog2(NBANK),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcfs_mode,
    input  logic              close_policy,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [COL_W-1:0]  enq_col,
    input  logic              enq_write,
    input  logic [NBANK-1:0]  bank_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre
);
    logic [DEPTH-1:0]               ent_valid;
    logic [DEPTH-1:0][BANK_W-1:0]   ent_bank;
    logic [DEPTH-1:0][ROW_W-1:0]    ent_row;
    logic [DEPTH-1:0][COL_W-1:0]    ent_col;
    logic [DEPTH-1:0]               ent_write;
    logic [DEPTH-1:0][DEPTH-1:0]    older;
    logic [NBANK-1:0]               open_valid;
    logic [NBANK-1:0][ROW_W-1:0]    open_row;
    logic [IDX_W-1:0]               pick_idx;
    logic                           deq_valid;

    // A column command (kind 0 or 1) retires its request.
    always_comb deq_valid = cmd_valid && !cmd_kind[1];

    req_store #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_bank(enq_bank), .enq_row(enq_row),
        .enq_col(enq_col), .enq_write(enq_write), .enq_ready(enq_ready),
        .deq_valid(deq_valid), .deq_idx(pick_idx),
        .ent_valid(ent_valid), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_col(ent_col), .ent_write(ent_write), .older(older)
    );

    bank_tracker #(.NBANK(NBANK), .ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_autopre(cmd_autopre),
        .open_valid(open_valid), .open_row(open_row)
    );

    cmd_picker #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
        .ent_valid(ent_valid), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_col(ent_col), .ent_write(ent_write), .older(older),
        .open_valid(open_valid), .open_row(open_row),
        .bank_ready(bank_ready), .fcfs_mode(fcfs_mode), .close_policy(close_policy),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
        .pick_idx(pick_idx)
    );
endmodule

// File: rtl/dram_cmd_sched_chk.sv
// Property checker for dram_cmd_sched.
// Keeps its own shadow of the open rows, built only from the issued
// commands, and checks each new command against it.
module dram_cmd_sched_chk #(
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              close_policy,
    input logic [NBANK-1:0]  bank_ready,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic              cmd_autopre
);
    logic [NBANK-1:0]            sh_open;
    logic [NBANK-1:0][ROW_W-1:0] sh_row;

    // Rebuild the open-row state from the command stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_open <= '0;
            sh_row  <= '0;
        end else if (cmd_valid) begin
            if (cmd_kind == 2'd2) begin
                sh_open[cmd_bank] <= 1'b1;
                sh_row[cmd_bank]  <= cmd_row;
            end else if (cmd_kind == 2'd3 || cmd_autopre) begin
                sh_open[cmd_bank] <= 1'b0;
            end
        end
    end

    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> bank_ready[cmd_bank]); // R7
    AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_kind[1]) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row)); // R1
    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> !sh_open[cmd_bank]); // R8
    AST_PRE_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd3) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] != cmd_row)); // R1
    AST_OPEN_POLICY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !close_policy) |-> !cmd_autopre); // R4
    AST_AUTOPRE_COLUMN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_autopre |-> (cmd_valid && !cmd_kind[1])); // R5
endmodule

bind dram_cmd_sched dram_cmd_sched_chk #(.NBANK(NBANK), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .close_policy(close_policy), .bank_ready(bank_ready),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_autopre(cmd_autopre)
);

// File: tb/sim_dram_cmd_sched.sv
`timescale 1ns/1ps
// Testbench with a behavioural reference model: an arrival-ordered queue
// plus per-bank open-row integers, compared with the outputs every cycle.
module sim_dram_cmd_sched;
    localparam int DEPTH = 8;
    localparam int NBANK = 4;
    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int BANK_W = 2;

    typedef struct { int bank; int row; int col; bit wr; } mreq_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fcfs_mode = 1'b0, close_policy = 1'b0;
    logic enq_valid = 1'b0, enq_write = 1'b0;
    logic [BANK_W-1:0] enq_bank = '0;
    logic [ROW_W-1:0]  enq_row = '0;
    logic [COL_W-1:0]  enq_col = '0;
    logic [NBANK-1:0]  bank_ready = '1;
    logic              enq_ready, cmd_valid, cmd_autopre;
    logic [1:0]        cmd_kind;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;

    int checks = 0, fails = 0, cyc_cnt = 0;
    string cur_tag = "R10";
    mreq_t q[$];
    int ob_v[NBANK];
    int ob_row[NBANK];

    always #2.5 clk = ~clk;

    dram_cmd_sched #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode), .close_policy(close_policy),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_col(enq_col), .enq_write(enq_write),
        .bank_ready(bank_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_autopre(cmd_autopre)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles (expected finish)", cyc_cnt);
            report();
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: check the outputs against the model, then advance the model.
    task automatic cyc();
        int pi = -1;
        bit ev = 0, ea = 0, acc;
        int ek = 0;
        #1;
        if (fcfs_mode) begin
            if (q.size() > 0 && bank_ready[q[0].bank]) pi = 0;
        end else begin
            foreach (q[i]) if (pi < 0 && bank_ready[q[i].bank] &&
                               ob_v[q[i].bank] != 0 && ob_row[q[i].bank] == q[i].row) pi = i;
            if (pi < 0) foreach (q[i]) if (pi < 0 && bank_ready[q[i].bank]) pi = i;
        end
        if (pi >= 0) begin
            bit h;
            ev = 1;
            h = ob_v[q[pi].bank] != 0 && ob_row[q[pi].bank] == q[pi].row;
            if (h) ek = q[pi].wr ? 1 : 0;
            else ek = (ob_v[q[pi].bank] != 0) ? 3 : 2;
            if (h && close_policy) begin
                ea = 1;
                foreach (q[j]) if (j != pi && q[j].bank == q[pi].bank && q[j].row == q[pi].row) ea = 0;
            end
        end
        chk("R9", int'(enq_ready), int'(q.size() < DEPTH), "enq_ready");
        chk(cur_tag, int'(cmd_valid), int'(ev), "cmd_valid");
        if (ev && cmd_valid) begin
            chk(cur_tag, int'(cmd_kind), ek, "cmd_kind");
            chk(cur_tag, int'(cmd_bank), q[pi].bank, "cmd_bank");
            chk(close_policy ? "R5" : "R4", int'(cmd_autopre), int'(ea), "cmd_autopre");
            if (ek == 2) chk("R1", int'(cmd_row), q[pi].row, "cmd_row");
            if (ek < 2)  chk("R1", int'(cmd_col), q[pi].col, "cmd_col");
        end
        acc = enq_valid && q.size() < DEPTH;
        @(posedge clk);
        if (ev) begin
            int b = q[pi].bank;
            if (ek == 2) begin ob_v[b] = 1; ob_row[b] = q[pi].row; end
            else if (ek == 3) ob_v[b] = 0;
            else begin
                if (ea) ob_v[b] = 0;
                q.delete(pi);
            end
        end
        if (acc) q.push_back('{bank: int'(enq_bank), row: int'(enq_row),
                               col: int'(enq_col), wr: enq_write});
        @(negedge clk);
    endtask

    task automatic put(int b, int r, int c, bit w);
        enq_valid = 1; enq_bank = BANK_W'(b); enq_row = ROW_W'(r);
        enq_col = COL_W'(c); enq_write = w;
        cyc();
        enq_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        for (int b = 0; b < NBANK; b++) begin ob_v[b] = 0; ob_row[b] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_tag = "R10";
        chk("R10", int'(cmd_valid), 0, "cmd_valid in reset");
        rst_n = 1;
        idle(1);
        chk("R10", int'(enq_ready), 1, "enq_ready after reset");

        // R1, R8: activate, read, then conflict -> precharge, activate, write.
        cur_tag = "R1";
        put(0, 5, 11, 0);
        idle(3);
        put(0, 7, 12, 1);
        idle(4);

        // R2, R3: build a mix with banks blocked, then release.
        cur_tag = "R2";
        bank_ready = '0;
        put(1, 3, 20, 0);
        put(2, 9, 21, 0);
        put(0, 7, 22, 0);
        put(0, 7, 23, 1);
        put(2, 9, 24, 1);
        bank_ready = '1;
        cur_tag = "R3";
        idle(10);

        // R7: only one bank ready.
        cur_tag = "R7";
        bank_ready = 4'b0010;
        put(3, 1, 30, 0);
        put(1, 4, 31, 0);
        idle(4);
        bank_ready = '0;
        idle(2);
        bank_ready = '1;
        idle(6);

        // R9: fill the buffer while blocked, then offer one more.
        cur_tag = "R9";
        bank_ready = '0;
        for (int i = 0; i < DEPTH + 1; i++) put(i % NBANK, 2, 40 + i, i[0]);
        chk("R9", int'(enq_ready), 0, "enq_ready when full");
        bank_ready = '1;
        idle(16);

        // R4 then R5: same-row pairs under each policy.
        cur_tag = "R4";
        close_policy = 0;
        put(2, 6, 50, 0);
        put(2, 6, 51, 0);
        idle(5);
        cur_tag = "R5";
        close_policy = 1;
        bank_ready = '0;
        put(3, 8, 52, 0);
        put(3, 8, 53, 1);
        put(1, 8, 54, 0);
        bank_ready = '1;
        idle(8);

        // R6: arrival order with the oldest bank blocked.
        cur_tag = "R6";
        close_policy = 0;
        fcfs_mode = 1;
        bank_ready = '0;
        put(0, 1, 60, 0);
        put(1, 1, 61, 0);
        bank_ready = 4'b0010;
        idle(3);
        bank_ready = '1;
        idle(6);
        fcfs_mode = 0;

        // R3: mixed traffic with varied modes and readiness.
        cur_tag = "R3";
        for (int seg = 0; seg < 40; seg++) begin
            fcfs_mode = ($urandom_range(0, 3) == 0);
            close_policy = $urandom_range(0, 1) != 0;
            for (int k = 0; k < 50; k++) begin
                bank_ready = NBANK'($urandom_range(0, 15));
                if ($urandom_range(0, 2) != 0)
                    put($urandom_range(0, NBANK - 1), $urandom_range(0, 3),
                        $urandom_range(0, 1023), $urandom_range(0, 1) != 0);
                else cyc();
            end
        end
        bank_ready = '1;
        fcfs_mode = 0;
        idle(30);

        report();
        $finish;
    end
endmodule